// File: doc/BRIEF.md
# Reloadable Trace Event Counter

This block is a down-counter for a trace-event subsystem. Each cycle in which its chosen count event is true, the count drops by one. The count can be refilled from a held reload value in three ways: by itself when a count event arrives while the count is already zero, when a second chosen event fires, or when the neighbouring counter below it in a chain reports zero. A combinational "at zero" flag goes to the resource logic that turns counter zeros into trace triggers.

Software sets up the counter through a single-cycle register write port with three targets: the control word, the reload value and the count itself. Both the count event and the reload event are chosen by 8-bit selector codes. The codes index a vector of decoded resource booleans. Resource 0 is fixed false and resource 1 is fixed true.

A typical use is a periodic timestamp trigger. Both values are set to 1, the count event is the always-true resource and self-reload is on. The counter then reaches zero on every other cycle.

Top module: `trace_evt_counter`

## Requirements
- R1: After reset the count is 0, `at_zero` is 1, and the control and reload values are 0. Because selector code 0 is the always-false resource, the count stays at 0 until it is written.
- R2: A write with `wr_addr` 0 loads the control word, 1 loads the reload value, and 2 loads the count, which appears on `count_out` after the next clock edge. A write with `wr_addr` 3 has no effect.
- R3: In a single-resource selector (bit 7 = 0), bits 4:0 give a resource index. The count decrements by exactly one on each cycle in which the selected count event (control bits 7:0) is true and no reload or count write occurs. The count holds otherwise.
- R4: Resource index 0 always reads false and resource index 1 always reads true, whatever the `res_vec` inputs are.
- R5: When a count event arrives while the count is 0, the count loads the reload value if control bit 16 (self-reload) is set. If bit 16 is clear, the count stays at 0.
- R6: The count loads the reload value on each cycle in which the reload event (control bits 15:8) is true, and this takes priority over a decrement. A reload selector naming resource 0 never causes a reload.
- R7: When control bit 17 (chain) is set, the count loads the reload value on each cycle in which `prev_zero` is high. When bit 17 is clear, `prev_zero` has no effect.
- R8: A write to the count register takes priority over every reload cause and over counting in the same cycle.
- R9: `at_zero` is high in exactly the cycles in which `count_out` is 0, with no added latency.
- R10: In a pair selector (bit 7 = 1), bits 3:0 give a pair number n, and the event is true when resource 2n or resource 2n+1 is true. Pair 0 is never true.
- R11: With count and reload both 1, an always-true count event and self-reload on, `at_zero` alternates on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1 reload, 2 count, 3 none |
| wr_data | input | DATA_W | Write data |
| res_vec | input | NUM_RES | Decoded resource booleans (entries 0 and 1 are overridden) |
| prev_zero | input | 1 | Zero flag of the previous counter in a chain |
| count_out | output | CNT_W | Current count |
| at_zero | output | 1 | High while the count is 0 |

## Verification
The bench targets the cases where a wrong design would misbehave. At the zero boundary, a design that wraps to all ones would report a huge count instead of holding or reloading. On reload priority, a design that decrements after an event or chain reload would show one less than the reload value. On write override, a reload that wins over a count write would lose the software value. In the selector decode, a design without the fixed resources, without the pair-0 exclusion, or with the pair bits read wrongly would count on idle inputs or miss a pair member. The periodic setup checks that self-reload happens only at zero and not on reaching zero, which is what sets the cadence to every other cycle.

// File: rtl/tec_pkg.sv
package tec_pkg;

  localparam int SEL_W   = 8;
  localparam int CTRL_W  = 18;
  localparam int RES_MAX = 32;

  // Control word: chain(17) self_rld(16) rld_sel(15:8) cnt_sel(7:0)
  typedef struct packed {
    logic             chain;
    logic             self_rld;
    logic [SEL_W-1:0] rld_sel;
    logic [SEL_W-1:0] cnt_sel;
  } ctrl_t;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_COUNT  = 2'd2,
    A_NONE   = 2'd3
  } waddr_e;

endpackage

// File: rtl/tec_sel_decode.sv
module tec_sel_decode #(
  parameter int NUM_RES = 32
) (
  input  logic [tec_pkg::SEL_W-1:0] code,
  input  logic [NUM_RES-1:0]        res,
  output logic                      hit
);
  import tec_pkg::*;

  logic [RES_MAX-1:0] pad;
  logic [3:0]         pair_n;
  logic [4:0]         lo_idx;
  logic [4:0]         hi_idx;
  logic               unused_sel_bits;

  genvar gi;
  generate
    for (gi = 0; gi < RES_MAX; gi++) begin : g_pad
      if (gi == 0) begin : g_false
        assign pad[gi] = 1'b0;
      end else if (gi == 1) begin : g_true
        assign pad[gi] = 1'b1;
      end else if (gi < NUM_RES) begin : g_in
        assign pad[gi] = res[gi];
      end else begin : g_absent
        assign pad[gi] = 1'b0;
      end
    end
  endgenerate

  assign unused_sel_bits = ^{code[6:5], res[1:0]};

  assign pair_n = code[3:0];
  assign lo_idx = {pair_n, 1'b0};
  assign hi_idx = {pair_n, 1'b1};

  always_comb begin
    if (code[7]) begin
      hit = (pair_n != 4'd0) && (pad[lo_idx] || pad[hi_idx]);
    end else begin
      hit = pad[code[4:0]];
    end
  end

endmodule

// File: rtl/tec_regs.sv
module tec_regs #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output tec_pkg::ctrl_t      ctrl,
  output logic [CNT_W-1:0]    reload,
  output logic                cnt_wr,
  output logic [CNT_W-1:0]    cnt_wdata
);
  import tec_pkg::*;

  localparam int USED_W = (CTRL_W > CNT_W) ? CTRL_W : CNT_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             ctrl_en, reload_en;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:USED_W];

  always_comb begin
    ctrl_en   = wr_en && (waddr_e'(wr_addr) == A_CTRL);
    reload_en = wr_en && (waddr_e'(wr_addr) == A_RELOAD);
    ctrl_d    = ctrl_t'(wr_data[CTRL_W-1:0]);
    reload_d  = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_en) begin
      reload_q <= reload_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign reload    = reload_q;
  assign cnt_wr    = wr_en && (waddr_e'(wr_addr) == A_COUNT);
  assign cnt_wdata = wr_data[CNT_W-1:0];

endmodule

// File: rtl/tec_count_core.sv
module tec_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             cnt_ev,
  input  logic             rld_ev,
  input  logic             chain_ev,
  input  logic             self_rld,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             is_zero;

  assign is_zero = (cnt_q == '0);

  // Priority: software write, then event/chain reload, then counting.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_wr) begin
      cnt_d  = cnt_wdata;
      cnt_en = 1'b1;
    end else if (rld_ev || chain_ev) begin
      cnt_d  = reload;
      cnt_en = 1'b1;
    end else if (cnt_ev) begin
      cnt_en = 1'b1;
      if (is_zero) begin
        cnt_d = self_rld ? reload : '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/trace_evt_counter.sv
module trace_evt_counter #(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_RES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_RES-1:0] res_vec,
  input  logic               prev_zero,
  output logic [CNT_W-1:0]   count_out,
  output logic               at_zero
);
  import tec_pkg::*;

  logic             rst_meta_n, rst_sync_n;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic             cnt_ev, rld_ev, chain_ev;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  tec_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl_q),
    .reload    (reload_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata)
  );

  tec_sel_decode #(.NUM_RES(NUM_RES)) u_cnt_sel (
    .code (ctrl_q.cnt_sel),
    .res  (res_vec),
    .hit  (cnt_ev)
  );

  tec_sel_decode #(.NUM_RES(NUM_RES)) u_rld_sel (
    .code (ctrl_q.rld_sel),
    .res  (res_vec),
    .hit  (rld_ev)
  );

  assign chain_ev = ctrl_q.chain && prev_zero;

  tec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .reload    (reload_q),
    .cnt_ev    (cnt_ev),
    .rld_ev    (rld_ev),
    .chain_ev  (chain_ev),
    .self_rld  (ctrl_q.self_rld),
    .count     (count_out)
  );

  assign at_zero = (count_out == '0);

endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                prev_zero,
  input tec_pkg::ctrl_t      ctrl_q,
  input logic [CNT_W-1:0]    reload_q,
  input logic                cnt_ev,
  input logic                rld_ev,
  input logic [CNT_W-1:0]    count_out
);

  logic wr_cnt;
  logic any_rld;
  assign wr_cnt  = wr_en && (wr_addr == 2'd2);
  assign any_rld = rld_ev || (ctrl_q.chain && prev_zero);

  p_count_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_cnt |=> count_out == $past(wr_data[CNT_W-1:0]));

  p_event_reload_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_cnt && rld_ev) |=> count_out == $past(reload_q));

  p_chain_reload_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_cnt && ctrl_q.chain && prev_zero) |=> count_out == $past(reload_q));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_cnt && !any_rld && cnt_ev && count_out != '0)
      |=> count_out == CNT_W'($past(count_out) - 1'b1));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_cnt && !any_rld && !cnt_ev) |=> $stable(count_out));

  p_zero_event_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_cnt && !any_rld && cnt_ev && count_out == '0)
      |=> count_out == ($past(ctrl_q.self_rld) ? $past(reload_q) : '0));

endmodule

bind trace_evt_counter tec_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .prev_zero  (prev_zero),
  .ctrl_q     (ctrl_q),
  .reload_q   (reload_q),
  .cnt_ev     (cnt_ev),
  .rld_ev     (rld_ev),
  .count_out  (count_out)
);

// File: tb/sim_trace_evt_counter.sv
`timescale 1ns/1ps
module sim_trace_evt_counter;

  localparam int CNT_W   = 16;
  localparam int DATA_W  = 32;
  localparam int NUM_RES = 32;

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [1:0]         wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic [NUM_RES-1:0] res_vec;
  logic               prev_zero;
  logic [CNT_W-1:0]   count_out;
  logic               at_zero;

  int checks = 0;
  int errors = 0;

  trace_evt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_RES(NUM_RES)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .res_vec   (res_vec),
    .prev_zero (prev_zero),
    .count_out (count_out),
    .at_zero   (at_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  // Freeze with ctrl 0, load values, then apply the final control word.
  task automatic setup(input logic [31:0] c, input int rl, input int cnt);
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, DATA_W'(rl));
    write_reg(2'd2, DATA_W'(cnt));
    write_reg(2'd0, c);
  endtask

  task automatic t_reset;
    check("R1 count after reset", int'(count_out), 0);
    check("R9 at_zero after reset", int'(at_zero), 1);
    res_vec = '1;
    step(3);
    check("R1 idle with ctrl 0", int'(count_out), 0);
    res_vec = '0;
  endtask

  task automatic t_write;
    write_reg(2'd1, 32'd5);
    write_reg(2'd2, 32'd7);
    check("R2 count write", int'(count_out), 7);
    check("R9 at_zero low", int'(at_zero), 0);
    write_reg(2'd3, 32'd99);
    check("R2 addr 3 ignored", int'(count_out), 7);
  endtask

  task automatic t_decrement;
    res_vec = '0;
    setup(32'h0000_0002, 5, 7);
    res_vec[2] = 1'b1;
    step(3);
    check("R3 decrement x3", int'(count_out), 4);
    res_vec[2] = 1'b0;
    step(2);
    check("R3 hold without event", int'(count_out), 4);
    setup(32'h0000_0001, 5, 4);
    step(1);
    check("R4 resource 1 always true", int'(count_out), 3);
    res_vec = '1;
    setup(32'h0000_0000, 5, 3);
    step(2);
    check("R4 resource 0 always false", int'(count_out), 3);
    res_vec = '0;
  endtask

  task automatic t_zero;
    setup(32'h0000_0001, 5, 2);
    step(2);
    check("R5 reached zero", int'(count_out), 0);
    check("R9 at_zero at zero", int'(at_zero), 1);
    step(2);
    check("R5 stays zero without self reload", int'(count_out), 0);
    setup(32'h0001_0001, 5, 0);
    step(1);
    check("R5 self reload at zero", int'(count_out), 5);
  endtask

  task automatic t_periodic;
    setup(32'h0001_0001, 1, 1);
    for (int i = 0; i < 6; i++) begin
      step(1);
      check("R11 alternating at_zero", int'(at_zero), (i % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_reload_event;
    res_vec = '0;
    setup(32'h0000_0301, 9, 6);
    step(1);
    check("R6 decrement before event", int'(count_out), 5);
    res_vec[3] = 1'b1;
    step(1);
    check("R6 reload beats decrement", int'(count_out), 9);
    res_vec[3] = 1'b0;
    step(1);
    check("R6 count resumes", int'(count_out), 8);
    res_vec = '1;
    setup(32'h0000_0001, 9, 6);
    step(2);
    check("R6 always-false reload never fires", int'(count_out), 4);
    res_vec = '0;
  endtask

  task automatic t_chain;
    prev_zero = 1'b0;
    setup(32'h0002_0000, 4, 10);
    prev_zero = 1'b1;
    step(1);
    check("R7 chained reload", int'(count_out), 4);
    prev_zero = 1'b0;
    setup(32'h0000_0000, 4, 10);
    prev_zero = 1'b1;
    step(1);
    check("R7 prev_zero ignored without chain", int'(count_out), 10);
    prev_zero = 1'b0;
  endtask

  task automatic t_override;
    prev_zero = 1'b0;
    setup(32'h0002_0101, 4, 10);
    prev_zero = 1'b1;
    write_reg(2'd2, 32'd20);
    check("R8 write beats reload and count", int'(count_out), 20);
    step(1);
    check("R8 reload after write", int'(count_out), 4);
    prev_zero = 1'b0;
  endtask

  task automatic t_pair;
    res_vec = '0;
    setup(32'h0000_0081, 0, 10);
    step(1);
    check("R10 pair idle", int'(count_out), 10);
    res_vec[3] = 1'b1;
    step(1);
    check("R10 pair odd member", int'(count_out), 9);
    res_vec = '0;
    res_vec[2] = 1'b1;
    step(1);
    check("R10 pair even member", int'(count_out), 8);
    res_vec = '1;
    setup(32'h0000_0080, 0, 10);
    step(2);
    check("R10 pair 0 never true", int'(count_out), 10);
    res_vec = '0;
    res_vec[31] = 1'b1;
    setup(32'h0000_008F, 0, 10);
    step(1);
    check("R10 top pair", int'(count_out), 9);
    res_vec = '0;
  endtask

  initial begin
    rst_n     = 1'b0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    res_vec   = '0;
    prev_zero = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_write();
    t_decrement();
    t_zero();
    t_periodic();
    t_reload_event();
    t_chain();
    t_override();
    t_pair();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule